// File: doc/BRIEF.md
# Nibble Logic Instruction Executor

This block executes the bitwise AND and OR instructions of a small 4-bit processor core. It holds the core's architectural state that these instructions touch: two 4-bit accumulators (A and B), two 8-bit data pointers (X and Y) and a 4-bit flag register. It decodes a 13-bit instruction word presented by the fetch logic. Operands come from a register, from a 4-bit immediate in the instruction, or from a nibble-wide data memory addressed through X or Y. Results go to an accumulator, to the flag register, or back to memory. The memory-pointer forms can advance the pointer they use.

The block accepts an instruction when `instr_valid` is high and `ready` is high. Register-destination and flag-destination forms finish in the accepting cycle. Memory-destination forms take a second cycle: the old nibble is read in the first cycle, and the combined nibble is written back in the second. `ready` is low during that second cycle. Memory is read asynchronously through `mem_addr` and `mem_rdata`, and it is written on the clock edge that ends the cycle in which `mem_we` is high.

Each completed instruction gives a one-cycle `retire` pulse. `retire_long` is high with it when the instruction used two cycles. A word that is not a valid encoding gives an `illegal` pulse and leaves all state alone.

Top module: `nibble_logic_exec`

## Requirements
- R1: After synchronous reset, A, B, X, Y and the flags are all zero, `ready` is 1 and `mem_we` is 0.
- R2: An instruction with bits 12..8 = 11010, bits 6..3 = 1110 combines two accumulators and writes the result into one of them. Bit 7 selects the operation: 0 is AND, 1 is OR. Bit 2 selects the destination and bit 1 the source (0 is A, 1 is B). The instruction completes in one cycle.
- R3: With bits 12..8 = 11010 and bits 6..5 = 10, the immediate in bits 3..0 is combined into A (bit 4 = 0) or into B (bit 4 = 1). The instruction completes in one cycle.
- R4: With bits 12..8 = 11010 and bits 6..3 = 1100, the source is the memory nibble at X (bit 1 = 0) or at Y (bit 1 = 1). Bit 2 selects the destination accumulator. The instruction completes in one cycle.
- R5: There are two memory-destination forms, both with bits 12..8 = 11010. In one, bits 6..3 = 1101 and bit 2 selects source A or B. In the other, bit 6 = 0 and the immediate is in bits 3..0. Both take two cycles. `mem_we` is high only in the second cycle, with the address of the first cycle.
- R6: The flag register holds E, I, C and Z in bits 3, 2, 1 and 0. For every non-flag destination, Z becomes 1 exactly when the 4-bit result is zero, and E, I and C keep their values.
- R7: Bits 12..5 = 10000100 select the flag form, with bit 7's role taken by bit 4 (0 is AND, 1 is OR). All four flags take the flag register combined with the immediate in bits 3..0, in one cycle.
- R8: Bit 0 of R4 and of the accumulator-to-memory form, and bit 4 of the immediate-to-memory form, request a post-increment. The selected pointer then advances by exactly one after the access, wrapping from 0xFF to 0x00. The other pointer is unchanged.
- R9: Any other word, including bits 12..8 = 11010 with bits 6..3 = 1111, gives a one-cycle `illegal` pulse. It changes no register, pointer, flag or memory nibble.
- R10: Each completed instruction gives one `retire` pulse in the cycle after its last clock edge. `retire_long` is 1 with it only for two-cycle forms.
- R11: While `ready` is low, `instr_valid` and `instr` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 13 | Instruction word |
| ready | output | 1 | Block can accept an instruction this cycle |
| mem_addr | output | 8 | Data memory nibble address |
| mem_rdata | input | 4 | Data memory read nibble (asynchronous) |
| mem_wdata | output | 4 | Data memory write nibble |
| mem_we | output | 1 | Data memory write enable |
| reg_a | output | 4 | Accumulator A |
| reg_b | output | 4 | Accumulator B |
| ptr_x | output | 8 | Pointer X |
| ptr_y | output | 8 | Pointer Y |
| flags | output | 4 | Flags {E, I, C, Z} |
| retire | output | 1 | Instruction completed |
| retire_long | output | 1 | Completed instruction took two cycles |
| illegal | output | 1 | Rejected an unknown instruction word |

## Verification
The assertions check rules that hold on every cycle:
- the write enable lasts exactly one cycle and keeps the block busy;
- a long retire always follows a write;
- pointers only ever step by one;
- I and C survive every register and memory form;
- a rejected word leaves the state frozen.

Only the bench scenarios can show that each encoding produces the right data. That covers the operand selected, AND against OR, the nibble written back, and where Z lands. The same holds for the pointer wrapping after 256 post-increments and for an instruction held on the inputs during a write-back being dropped.

// File: rtl/nle_pkg.sv
package nle_pkg;

  localparam int unsigned NIB_W   = 4;
  localparam int unsigned INSTR_W = 13;

  typedef enum logic [1:0] {
    DST_REG  = 2'd0,
    DST_MEM  = 2'd1,
    DST_FLAG = 2'd2
  } dst_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_IMM = 2'd1,
    SRC_MEM = 2'd2
  } src_e;

  typedef enum logic {
    ST_ISSUE = 1'b0,
    ST_WBACK = 1'b1
  } state_e;

  typedef struct packed {
    logic             legal;
    logic             is_or;
    dst_e             dst;
    src_e             src;
    logic             dst_b;     // register destination: 0 = A, 1 = B
    logic             src_b;     // register source: 0 = A, 1 = B
    logic             use_y;     // memory operand pointer: 0 = X, 1 = Y
    logic             post_inc;
    logic [NIB_W-1:0] imm;
  } decode_t;

endpackage

// File: rtl/nle_decoder.sv
module nle_decoder
  import nle_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output decode_t            dec
);

  localparam logic [4:0] MAJOR_LOGIC = 5'b11010;
  localparam logic [7:0] MAJOR_FLAG  = 8'b10000100;

  always_comb begin
    dec          = '0;
    dec.dst      = DST_REG;
    dec.src      = SRC_REG;
    dec.imm      = instr[3:0];
    if (instr[12:8] == MAJOR_LOGIC) begin
      dec.is_or = instr[7];
      unique case (instr[6:5])
        2'b11: begin
          if (!instr[3]) begin
            // register destination, register or memory source
            dec.legal    = 1'b1;
            dec.dst      = DST_REG;
            dec.dst_b    = instr[2];
            if (instr[4]) begin
              dec.src    = SRC_REG;
              dec.src_b  = instr[1];
            end else begin
              dec.src      = SRC_MEM;
              dec.use_y    = instr[1];
              dec.post_inc = instr[0];
            end
          end else if (!instr[4]) begin
            // accumulator into memory
            dec.legal    = 1'b1;
            dec.dst      = DST_MEM;
            dec.src      = SRC_REG;
            dec.src_b    = instr[2];
            dec.use_y    = instr[1];
            dec.post_inc = instr[0];
          end else begin
            dec.legal    = 1'b0;
          end
        end
        2'b10: begin
          dec.legal = 1'b1;
          dec.dst   = DST_REG;
          dec.src   = SRC_IMM;
          dec.dst_b = instr[4];
        end
        default: begin
          // immediate into memory
          dec.legal    = 1'b1;
          dec.dst      = DST_MEM;
          dec.src      = SRC_IMM;
          dec.use_y    = instr[5];
          dec.post_inc = instr[4];
        end
      endcase
    end else if (instr[12:5] == MAJOR_FLAG) begin
      dec.legal = 1'b1;
      dec.is_or = instr[4];
      dec.dst   = DST_FLAG;
      dec.src   = SRC_IMM;
    end
  end

endmodule

// File: rtl/nle_logic_unit.sv
module nle_logic_unit #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         is_or,
  output logic [W-1:0] res,
  output logic         zero
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign res[i] = is_or ? (lhs[i] | rhs[i]) : (lhs[i] & rhs[i]);
  end

  assign zero = ~|res;

endmodule

// File: rtl/nle_arch_regs.sv
module nle_arch_regs
  import nle_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic [NIB_W-1:0] acc_in,
  input  logic             wr_flags,
  input  logic [NIB_W-1:0] flags_in,
  input  logic             wr_z,
  input  logic             z_in,
  input  logic [1:0]       ptr_inc,
  output logic [NIB_W-1:0] acc_a,
  output logic [NIB_W-1:0] acc_b,
  output logic [AW-1:0]    ptr0,
  output logic [AW-1:0]    ptr1,
  output logic [NIB_W-1:0] flag_q
);

  logic [AW-1:0] ptr_q [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a <= '0;
      acc_b <= '0;
    end else begin
      if (wr_a) acc_a <= acc_in;
      if (wr_b) acc_b <= acc_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else if (wr_flags) begin
      flag_q <= flags_in;
    end else if (wr_z) begin
      flag_q[0] <= z_in;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[p] <= '0;
      end else if (ptr_inc[p]) begin
        ptr_q[p] <= ptr_q[p] + AW'(1);
      end
    end
  end

  assign ptr0 = ptr_q[0];
  assign ptr1 = ptr_q[1];

endmodule

// File: rtl/nibble_logic_exec.sv
module nibble_logic_exec
  import nle_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  output logic               ready,
  output logic [AW-1:0]      mem_addr,
  input  logic [NIB_W-1:0]   mem_rdata,
  output logic [NIB_W-1:0]   mem_wdata,
  output logic               mem_we,
  output logic [NIB_W-1:0]   reg_a,
  output logic [NIB_W-1:0]   reg_b,
  output logic [AW-1:0]      ptr_x,
  output logic [AW-1:0]      ptr_y,
  output logic [NIB_W-1:0]   flags,
  output logic               retire,
  output logic               retire_long,
  output logic               illegal
);

  decode_t          dec;
  state_e           state_q;
  logic             accept;
  logic             exec_ok;
  logic [AW-1:0]    ptr_sel;
  logic [NIB_W-1:0] lhs;
  logic [NIB_W-1:0] rhs;
  logic [NIB_W-1:0] res;
  logic             res_zero;

  logic [AW-1:0]    addr_q;
  logic [NIB_W-1:0] wdata_q;
  logic             z_q;
  logic             inc_pend_q;
  logic             sel_y_q;
  logic             retire_q;
  logic             long_q;
  logic             illegal_q;

  logic             wr_a;
  logic             wr_b;
  logic             wr_flags;
  logic             wr_z;
  logic             z_in;
  logic [1:0]       ptr_inc;

  nle_decoder u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign accept  = instr_valid && (state_q == ST_ISSUE);
  assign exec_ok = accept && dec.legal;
  assign ptr_sel = dec.use_y ? ptr_y : ptr_x;

  // left operand: the value being overwritten
  always_comb begin
    unique case (dec.dst)
      DST_MEM:  lhs = mem_rdata;
      DST_FLAG: lhs = flags;
      default:  lhs = dec.dst_b ? reg_b : reg_a;
    endcase
  end

  // right operand: the source
  always_comb begin
    unique case (dec.src)
      SRC_IMM: rhs = dec.imm;
      SRC_MEM: rhs = mem_rdata;
      default: rhs = dec.src_b ? reg_b : reg_a;
    endcase
  end

  nle_logic_unit #(.W(NIB_W)) u_alu (
    .lhs   (lhs),
    .rhs   (rhs),
    .is_or (dec.is_or),
    .res   (res),
    .zero  (res_zero)
  );

  // architectural register write controls
  always_comb begin
    wr_a     = 1'b0;
    wr_b     = 1'b0;
    wr_flags = 1'b0;
    wr_z     = 1'b0;
    z_in     = res_zero;
    ptr_inc  = 2'b00;
    if (state_q == ST_WBACK) begin
      wr_z = 1'b1;
      z_in = z_q;
      if (inc_pend_q) ptr_inc[sel_y_q] = 1'b1;
    end else if (exec_ok) begin
      unique case (dec.dst)
        DST_REG: begin
          wr_a = !dec.dst_b;
          wr_b = dec.dst_b;
          wr_z = 1'b1;
          if (dec.src == SRC_MEM && dec.post_inc) ptr_inc[dec.use_y] = 1'b1;
        end
        DST_FLAG: wr_flags = 1'b1;
        default: ;
      endcase
    end
  end

  nle_arch_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_a     (wr_a),
    .wr_b     (wr_b),
    .acc_in   (res),
    .wr_flags (wr_flags),
    .flags_in (res),
    .wr_z     (wr_z),
    .z_in     (z_in),
    .ptr_inc  (ptr_inc),
    .acc_a    (reg_a),
    .acc_b    (reg_b),
    .ptr0     (ptr_x),
    .ptr1     (ptr_y),
    .flag_q   (flags)
  );

  // sequencer for the read-modify-write forms
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_ISSUE;
      addr_q     <= '0;
      wdata_q    <= '0;
      z_q        <= 1'b0;
      inc_pend_q <= 1'b0;
      sel_y_q    <= 1'b0;
    end else if (state_q == ST_WBACK) begin
      state_q    <= ST_ISSUE;
      inc_pend_q <= 1'b0;
    end else if (exec_ok && dec.dst == DST_MEM) begin
      state_q    <= ST_WBACK;
      addr_q     <= ptr_sel;
      wdata_q    <= res;
      z_q        <= res_zero;
      inc_pend_q <= dec.post_inc;
      sel_y_q    <= dec.use_y;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      retire_q  <= 1'b0;
      long_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      retire_q  <= (state_q == ST_WBACK) || (exec_ok && dec.dst != DST_MEM);
      long_q    <= (state_q == ST_WBACK);
      illegal_q <= accept && !dec.legal;
    end
  end

  assign ready       = (state_q == ST_ISSUE);
  assign mem_addr    = (state_q == ST_WBACK) ? addr_q : ptr_sel;
  assign mem_wdata   = wdata_q;
  assign mem_we      = (state_q == ST_WBACK);
  assign retire      = retire_q;
  assign retire_long = long_q;
  assign illegal     = illegal_q;

endmodule

// File: rtl/nle_exec_chk.sv
module nle_exec_chk
  import nle_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               ready,
  input logic               mem_we,
  input logic [NIB_W-1:0]   reg_a,
  input logic [NIB_W-1:0]   reg_b,
  input logic [AW-1:0]      ptr_x,
  input logic [AW-1:0]      ptr_y,
  input logic [NIB_W-1:0]   flags,
  input logic               retire,
  input logic               retire_long,
  input logic               illegal
);

  p_we_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_busy_while_write_r11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !ready);

  p_long_follows_write_r10: assert property (@(posedge clk) disable iff (rst)
    retire_long |-> (retire && $past(mem_we)));

  p_retire_or_illegal_r10: assert property (@(posedge clk) disable iff (rst)
    !(retire && illegal));

  p_illegal_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (reg_a == $past(reg_a) && reg_b == $past(reg_b) &&
                 ptr_x == $past(ptr_x) && ptr_y == $past(ptr_y) &&
                 flags == $past(flags)));

  p_ptr_x_step_r8: assert property (@(posedge clk) disable iff (rst)
    (ptr_x != $past(ptr_x)) |-> (ptr_x == $past(ptr_x) + AW'(1)));

  p_ptr_y_step_r8: assert property (@(posedge clk) disable iff (rst)
    (ptr_y != $past(ptr_y)) |-> (ptr_y == $past(ptr_y) + AW'(1)));

  p_ic_kept_issue_r6: assert property (@(posedge clk) disable iff (rst)
    $past(ready && instr_valid && instr[12:8] == 5'b11010) |->
      (flags[3:1] == $past(flags[3:1])));

  p_eic_kept_wback_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (flags[3:1] == $past(flags[3:1])));

endmodule

bind nibble_logic_exec nle_exec_chk #(.AW(AW)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr       (instr),
  .ready       (ready),
  .mem_we      (mem_we),
  .reg_a       (reg_a),
  .reg_b       (reg_b),
  .ptr_x       (ptr_x),
  .ptr_y       (ptr_y),
  .flags       (flags),
  .retire      (retire),
  .retire_long (retire_long),
  .illegal     (illegal)
);

// File: tb/test_nibble_logic_exec.sv
module test_nibble_logic_exec;

  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          instr_valid = 1'b0;
  logic [12:0]   instr = '0;
  logic          ready;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_rdata;
  logic [3:0]    mem_wdata;
  logic          mem_we;
  logic [3:0]    reg_a, reg_b, flags;
  logic [AW-1:0] ptr_x, ptr_y;
  logic          retire, retire_long, illegal;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nibble_logic_exec #(.AW(AW)) i_nibble_logic_exec (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .ready(ready), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .reg_a(reg_a), .reg_b(reg_b),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .flags(flags), .retire(retire),
    .retire_long(retire_long), .illegal(illegal)
  );

  // data memory: asynchronous read, write on the clock edge
  logic [3:0] ram [DEPTH];
  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  // reference model state
  logic [3:0]    m_a = '0, m_b = '0, m_f = '0;
  logic [AW-1:0] m_x = '0, m_y = '0;
  logic [3:0]    m_mem [DEPTH];

  typedef struct packed {
    logic [3:0]    a, b, f;
    logic [AW-1:0] x, y;
    logic          ill, lng;
    logic [AW-1:0] addr;
    logic [3:0]    memv;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];

  task automatic check(input string tag, input logic ok, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [3:0] lop(input logic o, input logic [3:0] l, input logic [3:0] r);
    return o ? (l | r) : (l & r);
  endfunction

  // executes one word on the model, from the requirement encodings
  task automatic model_step(input logic [12:0] op, output logic ill,
                            output logic lng, output logic [AW-1:0] addr);
    logic [3:0]    d, s, r;
    logic [AW-1:0] p;
    ill = 1'b0; lng = 1'b0; addr = '0;
    casez (op)
      13'b11010_?_1110_???: begin           // R2 register to register
        s = op[1] ? m_b : m_a;
        d = op[2] ? m_b : m_a;
        r = lop(op[7], d, s);
        if (op[2]) m_b = r; else m_a = r;
        m_f[0] = (r == 4'h0);
      end
      13'b11010_?_1100_???: begin           // R4 memory to register
        p = op[1] ? m_y : m_x;
        d = op[2] ? m_b : m_a;
        r = lop(op[7], d, m_mem[p]);
        if (op[2]) m_b = r; else m_a = r;
        m_f[0] = (r == 4'h0);
        if (op[0]) begin if (op[1]) m_y = m_y + 1'b1; else m_x = m_x + 1'b1; end
      end
      13'b11010_?_10_?_????: begin          // R3 immediate to register
        d = op[4] ? m_b : m_a;
        r = lop(op[7], d, op[3:0]);
        if (op[4]) m_b = r; else m_a = r;
        m_f[0] = (r == 4'h0);
      end
      13'b11010_?_1101_???: begin           // R5 accumulator to memory
        p = op[1] ? m_y : m_x;
        r = lop(op[7], m_mem[p], op[2] ? m_b : m_a);
        m_mem[p] = r; addr = p; lng = 1'b1;
        m_f[0] = (r == 4'h0);
        if (op[0]) begin if (op[1]) m_y = m_y + 1'b1; else m_x = m_x + 1'b1; end
      end
      13'b11010_?_0_??_????: begin          // R5 immediate to memory
        p = op[5] ? m_y : m_x;
        r = lop(op[7], m_mem[p], op[3:0]);
        m_mem[p] = r; addr = p; lng = 1'b1;
        m_f[0] = (r == 4'h0);
        if (op[4]) begin if (op[5]) m_y = m_y + 1'b1; else m_x = m_x + 1'b1; end
      end
      13'b10000100_?_????: begin            // R7 flag form
        m_f = lop(op[4], m_f, op[3:0]);
      end
      default: ill = 1'b1;                  // R9
    endcase
  endtask

  // driver: updates the model, pushes the expected item, drives the word
  task automatic issue(input logic [12:0] op, input string tag,
                       input logic hold = 1'b0, input logic [12:0] intruder = '0);
    logic ill, lng;
    logic [AW-1:0] addr;
    exp_t e;
    model_step(op, ill, lng, addr);
    e.a = m_a; e.b = m_b; e.f = m_f; e.x = m_x; e.y = m_y;
    e.ill = ill; e.lng = lng; e.addr = addr; e.memv = m_mem[addr];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    instr_valid = 1'b1;
    instr = op;
    @(negedge clk);
    if (lng && hold) instr = intruder;
    else instr_valid = 1'b0;
    if (lng) begin
      @(negedge clk);
      instr_valid = 1'b0;
    end
  endtask

  // monitor: pops and compares each result as it appears
  always @(negedge clk) begin
    if (!rst && (retire || illegal)) begin
      if (exp_q.size() == 0) begin
        check("R10", 1'b0, "unexpected completion", {15'd0, retire}, 16'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, reg_a == e.a, "reg_a", 16'(reg_a), 16'(e.a));
        check(t, reg_b == e.b, "reg_b", 16'(reg_b), 16'(e.b));
        check(t, flags == e.f, "flags", 16'(flags), 16'(e.f));
        check(t, ptr_x == e.x, "ptr_x", 16'(ptr_x), 16'(e.x));
        check(t, ptr_y == e.y, "ptr_y", 16'(ptr_y), 16'(e.y));
        check(t, illegal == e.ill, "illegal", 16'(illegal), 16'(e.ill));
        check("R10", retire == !e.ill, "retire", 16'(retire), 16'(!e.ill));
        check("R10", retire_long == e.lng, "retire_long", 16'(retire_long), 16'(e.lng));
        check(t, ram[e.addr] == e.memv, "memory", 16'(ram[e.addr]), 16'(e.memv));
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram[i]   = 4'((i * 7 + 3) & 15);
      m_mem[i] = 4'((i * 7 + 3) & 15);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1", reg_a == 4'h0 && reg_b == 4'h0, "accumulators", {8'd0, reg_a, reg_b}, 16'd0);
    check("R1", ptr_x == '0 && ptr_y == '0, "pointers", {ptr_x, ptr_y}, 16'd0);
    check("R1", flags == 4'h0, "flags", 16'(flags), 16'd0);
    check("R1", ready == 1'b1 && mem_we == 1'b0, "ready/we", {14'd0, ready, mem_we}, 16'h2);

    // R3 immediates into A and B, R6 Z from result
    issue({5'b11010, 1'b1, 2'b10, 1'b0, 4'hA}, "R3");
    issue({5'b11010, 1'b1, 2'b10, 1'b1, 4'h5}, "R3");
    issue({5'b11010, 1'b0, 2'b10, 1'b0, 4'h0}, "R6");
    issue({5'b11010, 1'b1, 2'b10, 1'b0, 4'hC}, "R3");
    issue({5'b11010, 1'b0, 2'b10, 1'b1, 4'h7}, "R3");

    // R2 register forms
    issue({5'b11010, 1'b0, 4'b1110, 1'b0, 1'b1, 1'b0}, "R2");
    issue({5'b11010, 1'b1, 4'b1110, 1'b1, 1'b0, 1'b1}, "R2");
    issue({5'b11010, 1'b1, 4'b1110, 1'b0, 1'b0, 1'b0}, "R2");
    issue({5'b11010, 1'b0, 4'b1110, 1'b1, 1'b1, 1'b0}, "R2");

    // R7 flag form, then R6 keeps E, I, C
    issue({8'b10000100, 1'b1, 4'hF}, "R7");
    issue({8'b10000100, 1'b0, 4'h9}, "R7");
    issue({8'b10000100, 1'b0, 4'h6}, "R7");
    issue({8'b10000100, 1'b1, 4'h6}, "R7");
    issue({5'b11010, 1'b1, 2'b10, 1'b0, 4'h3}, "R6");
    issue({5'b11010, 1'b0, 2'b10, 1'b1, 4'h0}, "R6");

    // R4 memory sources, with and without post-increment (R8)
    issue({5'b11010, 1'b1, 4'b1100, 1'b0, 1'b0, 1'b0}, "R4");
    issue({5'b11010, 1'b0, 4'b1100, 1'b1, 1'b1, 1'b1}, "R4");
    issue({5'b11010, 1'b1, 4'b1100, 1'b1, 1'b1, 1'b1}, "R8");
    issue({5'b11010, 1'b1, 4'b1100, 1'b0, 1'b0, 1'b1}, "R8");

    // R5 memory destinations
    issue({5'b11010, 1'b1, 4'b1101, 1'b0, 1'b0, 1'b0}, "R5");
    issue({5'b11010, 1'b0, 4'b1101, 1'b1, 1'b1, 1'b1}, "R5");
    issue({5'b11010, 1'b1, 1'b0, 1'b0, 1'b1, 4'h9}, "R5");
    issue({5'b11010, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0}, "R5");
    issue({5'b11010, 1'b1, 1'b0, 1'b1, 1'b1, 4'h2}, "R8");

    // R11 word held on the inputs during write-back is dropped
    issue({5'b11010, 1'b1, 1'b0, 1'b0, 1'b0, 4'h1}, "R11", 1'b1,
          {5'b11010, 1'b1, 2'b10, 1'b1, 4'hF});
    @(negedge clk);
    check("R11", reg_b == m_b, "reg_b after held word", 16'(reg_b), 16'(m_b));
    check("R11", !retire && !illegal, "no extra completion", {14'd0, retire, illegal}, 16'd0);

    // R9 illegal words
    issue(13'h0000, "R9");
    issue({5'b11010, 1'b0, 4'b1111, 3'b000}, "R9");
    issue({5'b11010, 1'b1, 4'b1111, 3'b101}, "R9");

    // R8 wrap: 256 post-increment reads through X
    begin
      logic [AW-1:0] start;
      start = m_x;
      for (int k = 0; k < DEPTH; k++)
        issue({5'b11010, 1'b1, 4'b1100, 1'b0, 1'b0, 1'b1}, "R8");
      @(negedge clk);
      check("R8", ptr_x == start, "ptr_x after full wrap", 16'(ptr_x), 16'(start));
    end

    repeat (3) @(negedge clk);
    check("R10", exp_q.size() == 0, "pending results", 16'(exp_q.size()), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule